// File: doc/BRIEF.md
# Multiply-Accumulate Engine with Arithmetic Modes

The engine multiplies two 32-bit operands and adds the product to, or subtracts it from, one of several 48-bit accumulators. A mode field picks how the operands are treated: unsigned integer, signed integer, or signed fraction (a 64-bit product scaled down by 24 bits, with optional round-to-nearest-even). Before it is accumulated, the product may be doubled or halved by a one-bit shift. Overflow is checked at two points: the product against a 40-bit range, and the sum against the 48-bit accumulator. When saturation is enabled, an overflowing result is clamped.

Alongside the multiply-accumulate operation the engine can clear an accumulator, load one from a 32-bit value, and copy one accumulator to another. A status word carries the mode, a sticky overflow bit for each accumulator, and the N, Z, V and EV result flags. Operations are issued one at a time over a valid/ready pair. The written accumulator value and the updated status appear one cycle after acceptance.

Top module: `mac_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, `res_valid` is 0, `status` is 0, and every accumulator is zero. `op_ready` rises one cycle after reset is released.
- R2: In signed-integer mode (mode bits: bit 3 saturate, bit 2 signed, bit 1 fraction, bit 0 round), a product that does not fit in a signed 40-bit value sets V. Without saturation the product is reduced to its low 40 bits, sign-extended. With saturation it becomes +2^50, or the bitwise complement of 2^50 when the product is negative.
- R3: In unsigned-integer mode, a product with any bit at position 40 or above sets V. Without saturation the product is truncated to 40 bits; with saturation it becomes 2^50.
- R4: In fraction mode the signed product is shifted right arithmetically by 24. With rounding enabled, a discarded part above 0x800000 adds one, and a discarded part equal to 0x800000 adds the low bit of the result, which rounds to even. With rounding off the discarded part is dropped.
- R5: `op_shift` = 1 doubles the product and `op_shift` = 2 halves it before accumulation. The halving is arithmetic in signed and fraction modes and logical in unsigned mode. Any other value leaves the product unchanged.
- R6: `op_code` = 0 adds the product to accumulator `op_acc`, or subtracts it when `op_sub` = 1. The operation sets the accumulator's sticky overflow bit (`status` bit 8 + index) whenever V arises. Multiply-accumulate never clears a sticky bit.
- R7: With saturation on and V raised, the written value is clamped. In signed-integer mode it becomes 0x7FFFFFFF or its sign-extended negative extreme. In fraction mode it becomes the 48-bit signed extreme. In unsigned mode it becomes 0 when the 64-bit sum exceeds 2^53, and 2^48-1 otherwise. A sum outside the signed 48-bit range (outside 0..2^48-1 when unsigned) raises V.
- R8: After each multiply-accumulate the flags are recomputed from the written value: Z (bit 2) when it is zero, N (bit 3) when bit 47 is set, and V (bit 1) equal to that accumulator's sticky bit. EV (bit 0) is set when bits 47..40 are not all equal in fraction mode, when bits 47..32 are not all equal in signed mode, and when any of bits 47..32 is set in unsigned mode.
- R9: `op_code` = 1 clears the accumulator. `op_code` = 3 loads the accumulator from `op_a`: shifted left by 8 and sign-extended in fraction mode, sign-extended in signed mode, and zero-extended otherwise. Both clear its sticky bit and leave N, Z, V and EV unchanged.
- R10: `op_code` = 2 copies accumulator `op_src` into `op_acc`, together with the source's sticky bit. The flags are left unchanged.
- R11: An operation is accepted when `op_valid` and `op_ready` are both high. `res_valid` and `res_acc` (the value written) follow on the next cycle, back-to-back operations are accepted every cycle, and with `op_valid` low nothing changes.
- R12: `cfg_we` writes `cfg_mode` into `status` bits 7..4 on the next edge. Operations already accepted keep the mode that was in force when they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the mode field |
| cfg_mode | input | 4 | New mode: saturate, signed, fraction, round |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Engine can accept an operation |
| op_code | input | 2 | 0 multiply-accumulate, 1 clear, 2 copy, 3 load |
| op_acc | input | $clog2(NUM_ACC) | Destination accumulator |
| op_src | input | $clog2(NUM_ACC) | Source accumulator for copy |
| op_a | input | 32 | First operand / load value |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | Subtract instead of add |
| op_shift | input | 2 | 0 none, 1 double, 2 halve |
| res_valid | output | 1 | Result of the previous accepted operation |
| res_acc | output | 48 | Value written to the destination accumulator |
| status | output | NUM_ACC+8 | Sticky bits, mode, N, Z, V, EV |

## Verification
The bench builds the engine with its default of four accumulators. This allows a copy into an accumulator whose sticky bit is then kept across later operations on other accumulators. It also allows all four sticky bits to be seen together in one status word, which tests the bit 8 + index placement. The driver moves through all three arithmetic modes, with and without saturation and rounding. The operands are chosen so that each product overflow, sum overflow, clamp, round-to-even tie and extension flag is hit at a known value.

// File: rtl/mac_pkg.sv
// Shared widths, opcodes and clamp constants for the multiply-accumulate engine.
// Assumes 32-bit operands and 48-bit accumulators; products are held in 64 bits.
package mac_pkg;
    localparam int OPW     = 32;
    localparam int ACCW    = 48;
    localparam int PW      = 2 * OPW;
    localparam int PRODW   = 40;
    localparam int FRAC_SH = 24;

    typedef enum logic [1:0] {
        OPC_MAC  = 2'd0,
        OPC_CLR  = 2'd1,
        OPC_COPY = 2'd2,
        OPC_LOAD = 2'd3
    } opc_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2
    } shf_e;

    localparam logic [PW-1:0]   FORCE_BIG = PW'(1) << 50;
    localparam logic [PW-1:0]   U_LIMIT   = PW'(1) << 53;
    localparam logic [ACCW-1:0] U_MAX     = {ACCW{1'b1}};
    localparam logic [ACCW-1:0] I_MAX     = ACCW'(32'h7FFF_FFFF);
    localparam logic [ACCW-1:0] I_MIN     = ~ACCW'(32'h7FFF_FFFF);
    localparam logic [ACCW-1:0] F_MAX     = {1'b0, {(ACCW-1){1'b1}}};
    localparam logic [ACCW-1:0] F_MIN     = {1'b1, {(ACCW-1){1'b0}}};
endpackage

// File: rtl/mac_product.sv
// Multiplier stage: forms the product under the active mode, applies the
// 40-bit product overflow rule or fractional scaling and rounding, then the
// optional one-bit shift. Purely combinational.
module mac_product
    import mac_pkg::*;
(
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic           sat_i,
    input  logic           sgn_i,
    input  logic           frac_i,
    input  logic           rnd_i,
    input  logic [1:0]     shift_i,
    output logic [PW-1:0]  tmp_o,
    output logic           povf_o
);
    localparam logic [FRAC_SH-1:0] HALF = FRAC_SH'(1) << (FRAC_SH - 1);

    logic signed [PW-1:0] ps;
    logic [PW-1:0]        pu;
    logic [PW-1:0]        fq;
    logic [PW-1:0]        q;
    logic [FRAC_SH-1:0]   rem;

    // Scale, round or range-limit the raw product according to the mode.
    always_comb begin
        ps     = $signed({{OPW{a_i[OPW-1]}}, a_i}) * $signed({{OPW{b_i[OPW-1]}}, b_i});
        pu     = {{OPW{1'b0}}, a_i} * {{OPW{1'b0}}, b_i};
        fq     = ps >>> FRAC_SH;
        rem    = ps[FRAC_SH-1:0];
        povf_o = 1'b0;
        q      = pu;
        if (frac_i) begin
            q = fq;
            if (rnd_i) begin
                if (rem > HALF)       q = fq + PW'(1);
                else if (rem == HALF) q = fq + PW'(fq[0]);
            end
        end else if (sgn_i) begin
            q = ps;
            if (ps[PW-1:PRODW-1] != {(PW-PRODW+1){ps[PRODW-1]}}) begin
                povf_o = 1'b1;
                if (sat_i) q = ps[PW-1] ? ~FORCE_BIG : FORCE_BIG;
                else       q = {{(PW-PRODW){ps[PRODW-1]}}, ps[PRODW-1:0]};
            end
        end else if (|pu[PW-1:PRODW]) begin
            povf_o = 1'b1;
            q      = sat_i ? FORCE_BIG : {{(PW-PRODW){1'b0}}, pu[PRODW-1:0]};
        end
    end

    // Optional doubling or halving of the scaled product.
    always_comb begin
        case (shift_i)
            SH_LEFT:  tmp_o = {q[PW-2:0], 1'b0};
            SH_RIGHT: tmp_o = {(sgn_i | frac_i) & q[PW-1], q[PW-1:1]};
            default:  tmp_o = q;
        endcase
    end
endmodule

// File: rtl/mac_sum.sv
// Accumulate stage: extends the accumulator, adds or subtracts the product,
// checks the 48-bit range and clamps when saturation is on. Combinational.
module mac_sum
    import mac_pkg::*;
(
    input  logic [ACCW-1:0] acc_i,
    input  logic [PW-1:0]   tmp_i,
    input  logic            sub_i,
    input  logic            povf_i,
    input  logic            sat_i,
    input  logic            sgn_i,
    input  logic            frac_i,
    output logic [ACCW-1:0] res_o,
    output logic            v_o
);
    logic [PW-1:0] accx;
    logic [PW-1:0] sum;
    logic          sovf;
    logic          signd;

    // Wide sum, range check and clamp selection.
    always_comb begin
        signd = sgn_i | frac_i;
        accx  = signd ? {{(PW-ACCW){acc_i[ACCW-1]}}, acc_i} : {{(PW-ACCW){1'b0}}, acc_i};
        sum   = sub_i ? accx - tmp_i : accx + tmp_i;
        sovf  = signd ? (sum[PW-1:ACCW-1] != {(PW-ACCW+1){sum[ACCW-1]}})
                      : (|sum[PW-1:ACCW]);
        v_o   = povf_i | sovf;
        res_o = sum[ACCW-1:0];
        if (v_o && sat_i) begin
            if (!signd)      res_o = (sum > U_LIMIT) ? '0 : U_MAX;
            else if (frac_i) res_o = sum[PW-1] ? F_MIN : F_MAX;
            else             res_o = sum[PW-1] ? I_MIN : I_MAX;
        end
    end
endmodule

// File: rtl/mac_flags.sv
// Flag stage: derives N, Z, V and EV from a freshly written accumulator.
// Assumes the caller passes the sticky bit already updated for this operation.
module mac_flags
    import mac_pkg::*;
(
    input  logic [ACCW-1:0] res_i,
    input  logic            sticky_i,
    input  logic            sgn_i,
    input  logic            frac_i,
    output logic [3:0]      flags_o
);
    logic [ACCW-PRODW-1:0] hi_f;
    logic [ACCW-OPW-1:0]   hi_i;
    logic                  ev;

    // Extension check sized by mode, then pack {N, Z, V, EV}.
    always_comb begin
        hi_f = res_i[ACCW-1:PRODW];
        hi_i = res_i[ACCW-1:OPW];
        if (frac_i)     ev = (hi_f != '0) && (hi_f != '1);
        else if (sgn_i) ev = (hi_i != '0) && (hi_i != '1);
        else            ev = (hi_i != '0);
        flags_o = {res_i[ACCW-1], res_i == '0, sticky_i, ev};
    end
endmodule

// File: rtl/mac_engine.sv
// Top of the multiply-accumulate engine: accumulator bank, sticky overflow
// bits, mode and flag registers, single-issue valid/ready operation port.
// Results are registered: visible the cycle after acceptance.
module mac_engine
    import mac_pkg::*;
#(
    parameter int NUM_ACC = 4,
    localparam int IW     = $clog2(NUM_ACC),
    localparam int STW    = NUM_ACC + 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [3:0]      cfg_mode,
    input  logic            op_valid,
    output logic            op_ready,
    input  logic [1:0]      op_code,
    input  logic [IW-1:0]   op_acc,
    input  logic [IW-1:0]   op_src,
    input  logic [OPW-1:0]  op_a,
    input  logic [OPW-1:0]  op_b,
    input  logic            op_sub,
    input  logic [1:0]      op_shift,
    output logic            res_valid,
    output logic [ACCW-1:0] res_acc,
    output logic [STW-1:0]  status
);
    logic [ACCW-1:0]    acc_q [NUM_ACC];
    logic [NUM_ACC-1:0] sticky_q;
    logic [3:0]         mode_q;
    logic [3:0]         flg_q;
    logic               ready_q;
    logic               rv_q;
    logic [ACCW-1:0]    racc_q;

    logic            fire;
    logic            m_sat, m_sgn, m_frac, m_rnd;
    logic [PW-1:0]   prod;
    logic            povf;
    logic [ACCW-1:0] mac_res;
    logic            mac_v;
    logic [3:0]      mac_flags_w;
    logic [ACCW-1:0] load_val;
    logic [ACCW-1:0] wr_data;

    assign {m_sat, m_sgn, m_frac, m_rnd} = mode_q;
    assign fire      = op_valid & ready_q;
    assign op_ready  = ready_q;
    assign res_valid = rv_q;
    assign res_acc   = racc_q;
    assign status    = {sticky_q, mode_q, flg_q};

    mac_product u_prod (
        .a_i(op_a), .b_i(op_b), .sat_i(m_sat), .sgn_i(m_sgn), .frac_i(m_frac),
        .rnd_i(m_rnd), .shift_i(op_shift), .tmp_o(prod), .povf_o(povf)
    );

    mac_sum u_sum (
        .acc_i(acc_q[op_acc]), .tmp_i(prod), .sub_i(op_sub), .povf_i(povf),
        .sat_i(m_sat), .sgn_i(m_sgn), .frac_i(m_frac), .res_o(mac_res), .v_o(mac_v)
    );

    mac_flags u_flags (
        .res_i(mac_res), .sticky_i(sticky_q[op_acc] | mac_v), .sgn_i(m_sgn),
        .frac_i(m_frac), .flags_o(mac_flags_w)
    );

    // Pick the value written to the destination accumulator for each opcode.
    always_comb begin
        if (m_frac)     load_val = {{(ACCW-OPW-8){op_a[OPW-1]}}, op_a, 8'h00};
        else if (m_sgn) load_val = {{(ACCW-OPW){op_a[OPW-1]}}, op_a};
        else            load_val = {{(ACCW-OPW){1'b0}}, op_a};
        case (op_code)
            OPC_MAC:  wr_data = mac_res;
            OPC_CLR:  wr_data = '0;
            OPC_COPY: wr_data = acc_q[op_src];
            default:  wr_data = load_val;
        endcase
    end

    // One register per accumulator, written when it is the accepted destination.
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n)                           acc_q[g] <= '0;
            else if (fire && op_acc == IW'(g))    acc_q[g] <= wr_data;
        end
    end

    // Sticky overflow bits: set by overflow, cleared by clear/load, copied by copy.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else if (fire) begin
            case (op_code)
                OPC_MAC:  if (mac_v) sticky_q[op_acc] <= 1'b1;
                OPC_COPY: sticky_q[op_acc] <= sticky_q[op_src];
                default:  sticky_q[op_acc] <= 1'b0;
            endcase
        end
    end

    // Mode, result flags, handshake and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            flg_q   <= '0;
            ready_q <= 1'b0;
            rv_q    <= 1'b0;
            racc_q  <= '0;
        end else begin
            ready_q <= 1'b1;
            rv_q    <= fire;
            if (cfg_we) mode_q <= cfg_mode;
            if (fire) begin
                racc_q <= wr_data;
                if (op_code == OPC_MAC) flg_q <= mac_flags_w;
            end
        end
    end

    a_r11_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> res_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !res_valid);
    a_r9_clear_drops_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (op_code == OPC_CLR || op_code == OPC_LOAD)) |=> !sticky_q[$past(op_acc)]);
    a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && op_code != OPC_MAC) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
    a_r8_v_follows_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_code == OPC_MAC) |=> (status[1] == sticky_q[$past(op_acc)]));
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_code == OPC_MAC) |=> (status[2] == (res_acc == '0)));
    a_r12_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (status[7:4] == $past(cfg_mode)));
endmodule

// File: tb/mac_engine_tb.sv
// Scoreboard bench: the driver queues the expected accumulator and status for
// each operation; the monitor compares them when res_valid appears.
module mac_engine_tb;
    localparam int NA = 4;

    typedef struct {
        logic [47:0] acc;
        logic [11:0] st;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_mode = '0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_code = '0;
    logic [1:0]  op_acc = '0;
    logic [1:0]  op_src = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        op_sub = 1'b0;
    logic [1:0]  op_shift = '0;
    logic        res_valid;
    logic [47:0] res_acc;
    logic [11:0] status;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    mac_engine #(.NUM_ACC(NA)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
        .op_acc(op_acc), .op_src(op_src), .op_a(op_a), .op_b(op_b),
        .op_sub(op_sub), .op_shift(op_shift), .res_valid(res_valid),
        .res_acc(res_acc), .status(status)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] code, input logic [1:0] acc,
                         input logic [1:0] src, input logic [31:0] a,
                         input logic [31:0] b, input logic sub, input logic [1:0] sh,
                         input logic [47:0] e_acc, input logic [11:0] e_st,
                         input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = 1'b0; op_valid = 1'b1; op_code = code; op_acc = acc; op_src = src;
        op_a = a; op_b = b; op_sub = sub; op_shift = sh;
        e.acc = e_acc; e.st = e_st; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic set_mode(input logic [3:0] m, input logic [11:0] e_st, input string tag);
        @(negedge clk);
        op_valid = 1'b0; cfg_we = 1'b1; cfg_mode = m;
        @(negedge clk);
        cfg_we = 1'b0;
        check(status == e_st, tag, 64'(status), 64'(e_st));
    endtask

    // Monitor: compare each result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11 unexpected result", 64'(res_acc), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (res_acc !== e.acc || status !== e.st) begin
                    errors++;
                    $display("FAIL %s: actual acc=%h st=%h expected acc=%h st=%h",
                             e.tag, res_acc, status, e.acc, e.st);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog expired: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 res_valid in reset", 64'(res_valid), 64'd0);
        check(status == 12'h000, "R1 status in reset", 64'(status), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(op_ready == 1'b1, "R1 ready after reset", 64'(op_ready), 64'd1);
        check(status == 12'h000 && res_valid == 1'b0, "R1 idle after reset",
              64'(status), 64'd0);

        // Unsigned integer mode, no saturation (back-to-back issue, R11).
        do_op(2'd0, 2'd0, 2'd0, 32'd3, 32'd5, 1'b0, 2'd0, 48'hF, 12'h000, "R6 add");
        do_op(2'd0, 2'd0, 2'd0, 32'd2, 32'd3, 1'b1, 2'd0, 48'h9, 12'h000, "R6 sub");
        do_op(2'd0, 2'd1, 2'd0, 32'h10000, 32'h10000, 1'b0, 2'd0,
              48'h0001_0000_0000, 12'h001, "R8 unsigned EV");
        do_op(2'd0, 2'd2, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'd0,
              48'h00FE_0000_0001, 12'h403, "R3 unsigned product overflow truncates");
        do_op(2'd2, 2'd3, 2'd2, 32'd0, 32'd0, 1'b0, 2'd0,
              48'h00FE_0000_0001, 12'hC03, "R10 copy value and sticky");
        do_op(2'd1, 2'd2, 2'd0, 32'd0, 32'd0, 1'b0, 2'd0, 48'h0, 12'h803,
              "R9 clear drops sticky");

        set_mode(4'b1000, 12'h883, "R12 mode write unsigned saturate");
        do_op(2'd0, 2'd0, 2'd0, 32'd4, 32'd5, 1'b1, 2'd0, 48'h0, 12'h986,
              "R7 unsigned underflow clamps to zero");
        do_op(2'd3, 2'd0, 2'd0, 32'h8000_0000, 32'd0, 1'b0, 2'd0,
              48'h0000_8000_0000, 12'h886, "R9 unsigned load zero-extends");

        set_mode(4'b1100, 12'h8C6, "R12 mode write signed saturate");
        do_op(2'd3, 2'd1, 2'd0, 32'hFFFF_FFFF, 32'd0, 1'b0, 2'd0,
              48'hFFFF_FFFF_FFFF, 12'h8C6, "R9 signed load sign-extends");

        // Ignored request: op_valid low with a clear of acc1 on the bus (R11).
        @(negedge clk);
        op_valid = 1'b0; op_code = 2'd1; op_acc = 2'd1;
        @(negedge clk);
        check(res_valid == 1'b0, "R11 no result without op_valid", 64'(res_valid), 64'd0);

        do_op(2'd0, 2'd1, 2'd0, 32'hFFFF_FFFF, 32'd7, 1'b0, 2'd1,
              48'hFFFF_FFFF_FFF1, 12'h8C8, "R5 double then add, R8 N, R11 acc1 kept");
        do_op(2'd0, 2'd1, 2'd0, 32'h4000_0000, 32'h4000_0000, 1'b0, 2'd0,
              48'h0000_7FFF_FFFF, 12'hAC2, "R2 signed forced overflow, R7 clamp");

        set_mode(4'b0100, 12'hA42, "R12 mode write signed");
        do_op(2'd0, 2'd0, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 2'd0,
              48'hFFFF_8000_0001, 12'hB4A, "R2 signed overflow keeps low 40 bits");

        set_mode(4'b0011, 12'hB3A, "R12 mode write fraction round");
        do_op(2'd3, 2'd2, 2'd0, 32'd1, 32'd0, 1'b0, 2'd0, 48'h100, 12'hB3A,
              "R9 fraction load shifts by 8");
        do_op(2'd0, 2'd2, 2'd0, 32'h0080_0000, 32'd3, 1'b0, 2'd0, 48'h102, 12'hB30,
              "R4 tie on odd rounds up");
        do_op(2'd0, 2'd2, 2'd0, 32'h0080_0000, 32'd5, 1'b1, 2'd0, 48'h100, 12'hB30,
              "R4 tie on even stays");
        do_op(2'd0, 2'd2, 2'd0, 32'h0100_0000, 32'd4, 1'b0, 2'd2, 48'h102, 12'hB30,
              "R5 halve then add");

        set_mode(4'b0010, 12'hB20, "R12 mode write fraction");
        do_op(2'd0, 2'd2, 2'd0, 32'h00C0_0000, 32'd1, 1'b0, 2'd0, 48'h102, 12'hB20,
              "R4 no rounding truncates");
        do_op(2'd3, 2'd2, 2'd0, 32'h7FFF_FFFF, 32'd0, 1'b0, 2'd0,
              48'h007F_FFFF_FF00, 12'hB20, "R9 fraction load max");
        do_op(2'd0, 2'd2, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 2'd1,
              48'h00FF_FFFF_FD00, 12'hB20, "R8 fraction no EV");
        do_op(2'd0, 2'd2, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 2'd1,
              48'h017F_FFFF_FB00, 12'hB21, "R8 fraction EV");

        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R11 every operation answered", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule